// File: doc/BRIEF.md
# Prioritised interrupt and bus-grant arbiter

This block sits next to a processor core's sequencer. At each boundary the core reports, it decides which pending event is serviced. There are three candidates. An external bus request is honoured at any machine-cycle boundary. A latched non-maskable event and a level-sensitive maskable request are serviced only at an instruction boundary. Granting the bus raises a float indication for the address, data and strobe drivers, and drives an active-low acknowledge for as long as the request is held. Servicing an interrupt produces a one-cycle start strobe, together with either a 16-bit target address or a flag telling the core to execute an opcode taken from the data bus.

The block holds the interrupt-enable flag, the 2-bit interrupt mode and the 8-bit vector-base register. The core updates these through load strobes. The block also contains its own reset qualifier, so a reset pulse shorter than three clock edges is ignored.

Top module: `irq_arbiter`

## Requirements
- R1: When rst_n is sampled low on three consecutive rising edges, the state is cleared at the third edge. After that, busack_n=1, bus_hiz=0, svc_start=0, interrupts are disabled, the mode is 0 and the vector base is 0x00.
- R2: A low pulse on rst_n that covers only two rising edges leaves the enable flag, the mode and the vector base unchanged.
- R3: When busrq_n is low at an edge where mcycle_end=1, busack_n goes low and bus_hiz goes high from that edge onward. While granted, busack_n returns high at the first edge where busrq_n is high. With mcycle_end=0, a request is not granted.
- R4: The bus grant has priority over both interrupts. No service starts at the edge where the grant is taken, and none starts while the bus is granted. A pending non-maskable event is kept and is serviced after the bus is released.
- R5: A falling edge on nmi_n is latched one edge after it occurs. The latched event is serviced at the next instruction boundary whatever the enable flag holds, with svc_nmi=1 and vec_addr=0x0066. Service clears the latch, so holding nmi_n low does not trigger a second service.
- R6: When a latched non-maskable event and a maskable request are both present at the same instruction boundary, the non-maskable event is serviced.
- R7: A maskable request (int_n low) starts service only at an edge where instr_end=1 and the enable flag is set. A mcycle_end strobe alone never starts service.
- R8: Mode 1 (mode value 2'b01, and also 2'b11) services a maskable request with vec_addr=0x0038 and exec_op=0.
- R9: Mode 2 (mode value 2'b10) services a maskable request with vec_addr = {vector base, data_in}. The vector base is loaded by ireg_wr.
- R10: Mode 0 (mode value 2'b00) services a maskable request with exec_op=1 and vec_addr = {8'h00, data_in}, which carries the opcode to be executed.
- R11: Accepting either kind of interrupt clears the enable flag at the same edge, so a maskable request that is still held low is not serviced again until ie_set.
- R12: When ie_set and ie_clr are both high at one edge, the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, qualified over three edges |
| busrq_n | input | 1 | Active-low external bus request |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Active-low maskable request, level sensitive |
| mcycle_end | input | 1 | Core strobe: machine-cycle boundary |
| instr_end | input | 1 | Core strobe: instruction boundary |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| mode_wr | input | 1 | Load the interrupt mode from mode_in |
| mode_in | input | 2 | New interrupt mode |
| ireg_wr | input | 1 | Load the vector base from ireg_in |
| ireg_in | input | 8 | New vector base |
| data_in | input | 8 | Byte driven on the data bus by the interrupting device |
| busack_n | output | 1 | Active-low bus acknowledge |
| bus_hiz | output | 1 | Float address, data and strobe drivers |
| svc_start | output | 1 | One-cycle strobe: interrupt service begins |
| svc_nmi | output | 1 | Last service was non-maskable |
| exec_op | output | 1 | Last service asks the core to execute vec_addr[7:0] as an opcode |
| vec_addr | output | 16 | Target address, or opcode in the low byte |

## Verification
Every cycle, the checker confirms several properties. No service starts while the bus is acknowledged. A grant appears only after a request at a machine-cycle boundary. A held grant drops one edge after the request is removed. Every service start follows an instruction boundary, a maskable service requires the enable flag to have been set, and the flag reads clear after any acceptance. Only the directed scenarios can show the remaining behaviour: the three vectoring modes and the target values they produce, the choice between the two interrupt kinds at the same boundary, and the non-maskable latch surviving a bus grant. They also cover the way the enable flag and mode react to a two-edge reset pulse compared with a full three-edge reset.

// File: rtl/irq_arbiter.sv
module irq_arbiter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busrq_n,
  input  logic        nmi_n,
  input  logic        int_n,
  input  logic        mcycle_end,
  input  logic        instr_end,
  input  logic        ie_set,
  input  logic        ie_clr,
  input  logic        mode_wr,
  input  logic [1:0]  mode_in,
  input  logic        ireg_wr,
  input  logic [7:0]  ireg_in,
  input  logic [7:0]  data_in,
  output logic        busack_n,
  output logic        bus_hiz,
  output logic        svc_start,
  output logic        svc_nmi,
  output logic        exec_op,
  output logic [15:0] vec_addr
);
  logic [1:0] rst_hist;
  logic       rst_eff;
  logic       granted, grant_now, take_ok, take_nmi, take_int;
  logic       nmi_q, nmi_pend, nmi_edge;
  logic       ie_q;
  logic [1:0] mode_q;
  logic [7:0] ireg_q;

  always_ff @(posedge clk) rst_hist <= {rst_hist[0], ~rst_n};
  assign rst_eff = ~rst_n & rst_hist[1] & rst_hist[0];

  assign grant_now = ~granted & ~busrq_n & mcycle_end;
  assign take_ok   = instr_end & ~granted & ~grant_now;
  assign take_nmi  = take_ok & nmi_pend;
  assign take_int  = take_ok & ~nmi_pend & ~int_n & ie_q;
  assign nmi_edge  = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      granted  <= 1'b0;
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      ie_q     <= 1'b0;
      mode_q   <= 2'b00;
      ireg_q   <= 8'h00;
    end else begin
      granted  <= granted ? ~busrq_n : grant_now;
      nmi_q    <= nmi_n;
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_edge;
      if (take_nmi | take_int) ie_q <= 1'b0;
      else if (ie_clr)         ie_q <= 1'b0;
      else if (ie_set)         ie_q <= 1'b1;
      if (mode_wr) mode_q <= mode_in;
      if (ireg_wr) ireg_q <= ireg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      svc_start <= 1'b0;
      svc_nmi   <= 1'b0;
      exec_op   <= 1'b0;
      vec_addr  <= 16'h0000;
    end else begin
      svc_start <= take_nmi | take_int;
      if (take_nmi) begin
        svc_nmi  <= 1'b1;
        exec_op  <= 1'b0;
        vec_addr <= 16'h0066;
      end else if (take_int) begin
        svc_nmi <= 1'b0;
        exec_op <= (mode_q == 2'b00);
        case (mode_q)
          2'b00:   vec_addr <= {8'h00, data_in};
          2'b10:   vec_addr <= {ireg_q, data_in};
          default: vec_addr <= 16'h0038;
        endcase
      end
    end
  end

  assign busack_n = ~granted;
  assign bus_hiz  = granted;
endmodule

module irq_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic busrq_n,
  input logic mcycle_end,
  input logic instr_end,
  input logic busack_n,
  input logic svc_start,
  input logic svc_nmi,
  input logic ie_q
);
  p_no_svc_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> !svc_start);
  p_grant_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busack_n) |-> $past(!busrq_n && mcycle_end));
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busack_n && busrq_n) |=> busack_n);
  p_svc_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_start |-> $past(instr_end));
  p_int_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_start && !svc_nmi) |-> $past(ie_q));
  p_ie_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    svc_start |-> !ie_q);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busrq_n(busrq_n), .mcycle_end(mcycle_end),
  .instr_end(instr_end), .busack_n(busack_n), .svc_start(svc_start),
  .svc_nmi(svc_nmi), .ie_q(ie_q)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busrq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1;
  logic mcycle_end = 1'b0, instr_end = 1'b0;
  logic ie_set = 1'b0, ie_clr = 1'b0, mode_wr = 1'b0, ireg_wr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic [7:0] ireg_in = 8'h00, data_in = 8'h00;
  logic busack_n, bus_hiz, svc_start, svc_nmi, exec_op;
  logic [15:0] vec_addr;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  irq_arbiter dut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic boundary();
    mcycle_end = 1'b1; instr_end = 1'b1; tick();
    mcycle_end = 1'b0; instr_end = 1'b0;
  endtask

  task automatic set_ie();   ie_set = 1'b1; tick(); ie_set = 1'b0; endtask
  task automatic set_mode(input logic [1:0] m);
    mode_in = m; mode_wr = 1'b1; tick(); mode_wr = 1'b0;
  endtask
  task automatic full_reset();
    rst_n = 1'b0; repeat (4) tick(); rst_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    check("R1 busack_n", busack_n, 1);
    check("R1 bus_hiz", bus_hiz, 0);
    check("R1 svc_start", svc_start, 0);
    int_n = 1'b0; boundary();
    check("R1 ie cleared, int ignored", svc_start, 0);
    set_ie(); data_in = 8'hC7; boundary();
    check("R10 svc_start", svc_start, 1);
    check("R10 exec_op", exec_op, 1);
    check("R10 opcode", vec_addr, 16'h00C7);
    check("R10 svc_nmi", svc_nmi, 0);
    boundary();
    check("R11 no repeat after accept", svc_start, 0);
    int_n = 1'b1; tick();
  endtask

  task automatic t_mode2_base();
    set_mode(2'b10); set_ie(); int_n = 1'b0; data_in = 8'hA5; boundary();
    check("R1 vector base reset to 0", vec_addr, 16'h00A5);
    ireg_in = 8'h3C; ireg_wr = 1'b1; tick(); ireg_wr = 1'b0;
    set_ie(); data_in = 8'h12; boundary();
    check("R9 mode2 target", vec_addr, 16'h3C12);
    check("R9 exec_op", exec_op, 0);
    int_n = 1'b1; tick();
  endtask

  task automatic t_mode1();
    set_mode(2'b01); set_ie(); int_n = 1'b0; data_in = 8'hFF; boundary();
    check("R8 mode1 target", vec_addr, 16'h0038);
    check("R8 exec_op", exec_op, 0);
    set_mode(2'b11); set_ie(); boundary();
    check("R8 mode3 start", svc_start, 1);
    check("R8 mode3 target", vec_addr, 16'h0038);
    int_n = 1'b1; tick();
  endtask

  task automatic t_level();
    set_ie(); int_n = 1'b0;
    mcycle_end = 1'b1; repeat (3) tick(); mcycle_end = 1'b0;
    check("R7 no start on mcycle_end", svc_start, 0);
    boundary();
    check("R7 start on instr_end", svc_start, 1);
    int_n = 1'b1; tick();
  endtask

  task automatic t_nmi();
    ie_clr = 1'b1; tick(); ie_clr = 1'b0;
    nmi_n = 1'b0; tick(); tick();
    boundary();
    check("R5 nmi start with ie=0", svc_start, 1);
    check("R5 svc_nmi", svc_nmi, 1);
    check("R5 target", vec_addr, 16'h0066);
    tick(); boundary();
    check("R5 held low no retrigger", svc_start, 0);
    nmi_n = 1'b1; tick();
  endtask

  task automatic t_prio();
    set_mode(2'b01); set_ie(); int_n = 1'b0;
    nmi_n = 1'b0; tick(); tick();
    boundary();
    check("R6 nmi wins", svc_nmi, 1);
    check("R6 target", vec_addr, 16'h0066);
    boundary();
    check("R11 int blocked after nmi", svc_start, 0);
    set_ie(); boundary();
    check("R11 int after ie_set", vec_addr, 16'h0038);
    nmi_n = 1'b1; int_n = 1'b1; tick();
  endtask

  task automatic t_bus();
    busrq_n = 1'b0; tick(); tick();
    check("R3 no grant without mcycle_end", busack_n, 1);
    mcycle_end = 1'b1; tick(); mcycle_end = 1'b0;
    check("R3 busack_n low", busack_n, 0);
    check("R3 bus_hiz high", bus_hiz, 1);
    set_ie(); int_n = 1'b0; boundary();
    check("R4 no service while granted", svc_start, 0);
    int_n = 1'b1; busrq_n = 1'b1; tick();
    check("R3 release", busack_n, 1);
    nmi_n = 1'b0; tick(); tick();
    busrq_n = 1'b0; boundary();
    check("R4 grant wins", busack_n, 0);
    check("R4 no start at grant", svc_start, 0);
    busrq_n = 1'b1; tick(); boundary();
    check("R4 nmi kept across grant", svc_start, 1);
    check("R4 nmi target", vec_addr, 16'h0066);
    nmi_n = 1'b1; tick();
  endtask

  task automatic t_reset_len();
    set_mode(2'b01); set_ie();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    int_n = 1'b0; data_in = 8'h55; boundary();
    check("R2 short pulse keeps ie", svc_start, 1);
    check("R2 short pulse keeps mode", vec_addr, 16'h0038);
    int_n = 1'b1; set_ie();
    rst_n = 1'b0; tick(); tick(); tick(); rst_n = 1'b1; tick();
    int_n = 1'b0; boundary();
    check("R1 three edges clear ie", svc_start, 0);
    int_n = 1'b1; tick();
  endtask

  task automatic t_ie_both();
    set_mode(2'b01); set_ie();
    ie_set = 1'b1; ie_clr = 1'b1; tick(); ie_set = 1'b0; ie_clr = 1'b0;
    int_n = 1'b0; boundary();
    check("R12 clear wins", svc_start, 0);
    int_n = 1'b1; tick();
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (5) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_mode2_base();
    t_mode1();
    t_level();
    t_nmi();
    t_prio();
    t_bus();
    t_reset_len();
    full_reset();
    t_ie_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule